// File: doc/BRIEF.md
# General-Purpose I/O Port with Alternate-Function Routing

This block is one parallel I/O port of a microcontroller-class chip. Each pin has a direction bit, an output latch bit and an alternate-select bit. An output pin drives its pad with the latch value. An input pin releases its pad: the output-enable is low. A pin handed to an on-chip peripheral takes its pad value and enable from that peripheral instead.

Pad inputs pass through a multi-flop synchronizer. The synchronized value is given to peripherals as their alternate input, and software can read it back.

Software writes use an address, a data word and a bit-enable mask, so a single pin can be changed without touching its neighbours. Reads are combinational from a separate read address.

Top module: `gpio_port`

## Requirements
- R1: After reset, direction, latch and alternate-select registers are all zero. Every pin is an input, and pad_oe is all zero.
- R2: A write to address 0 (direction, 1 = output), 1 (latch) or 2 (alternate select, 1 = peripheral) updates only the bits whose wr_mask bit is 1. Other bits keep their value.
- R3: A pin with alternate select 0 drives pad_out from its latch bit and pad_oe from its direction bit.
- R4: A pin with alternate select 1 drives pad_out from alt_out and pad_oe from alt_oe. Its latch and direction bits have no effect on the pad.
- R5: pin_sync shows a pad_in value after two rising clock edges. It is zero after reset.
- R6: Reading address 3 returns, for each pin, the latch bit when its direction bit is 1 and the synchronized pad value when it is 0.
- R7: Reading addresses 0, 1 and 2 returns the direction, latch and alternate-select registers.
- R8: A write to address 3 changes no register.
- R9: A write with an all-zero mask changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | WIDTH | Write data |
| wr_mask | input | WIDTH | Per-bit write enable |
| rd_addr | input | 2 | Read register select |
| rd_data | output | WIDTH | Read data (combinational) |
| pad_in | input | WIDTH | Values seen on the pads |
| pad_out | output | WIDTH | Value driven to each pad |
| pad_oe | output | WIDTH | Pad output-enable, 0 = high impedance |
| alt_out | input | WIDTH | Peripheral output values |
| alt_oe | input | WIDTH | Peripheral output-enables |
| pin_sync | output | WIDTH | Synchronized pad inputs for peripherals |

## Verification
The bench builds the port with its defaults: sixteen pins and a two-stage synchronizer. At this width, random masks, data and select patterns quickly reach mixes of input, output and alternate pins within one word. The two-stage depth keeps the synchronizer latency visible, so an input change can be tracked through both flops to the read port. Directed cases cover all-zero and all-ones masks, writes to the read-only address, and a pin whose alternate select overrides a latch and direction that disagree with the peripheral.

// File: rtl/gpio_pkg.sv
// Shared register addresses for the GPIO port.
// Assumes a two-bit register address space.
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIR = 2'd0,
        REG_LAT = 2'd1,
        REG_ALT = 2'd2,
        REG_PIN = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_maskreg.sv
// Bit-masked register: on a write strobe, only bits with a mask bit of 1
// take the new data. Assumes the strobe is already qualified by address.
module gpio_maskreg #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [WIDTH-1:0] wr_mask,
    output logic [WIDTH-1:0] q
);
    // Masked update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= (q & ~wr_mask) | (wr_data & wr_mask);
    end
endmodule

// File: rtl/gpio_sync.sv
// Multi-stage synchronizer for pad inputs. Assumes STAGES >= 1.
// All stages clear on reset.
module gpio_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // One flop stage of the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_padmux.sv
// Per-pin pad steering. Selects the software latch and direction, or the
// peripheral value and enable, for each pin. Purely combinational.
module gpio_padmux #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    input  logic [WIDTH-1:0] alt_q,
    input  logic [WIDTH-1:0] alt_out,
    input  logic [WIDTH-1:0] alt_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Choose the driver of pad i.
        always_comb begin
            if (alt_q[i]) begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
            end else begin
                pad_out[i] = lat_q[i];
                pad_oe[i]  = dir_q[i];
            end
        end
    end
endmodule

// File: rtl/gpio_port.sv
// GPIO port top: three masked registers (direction, latch, alternate select),
// a pad input synchronizer, per-pin pad steering and a read mux.
// Assumes the pads are sampled asynchronously and that reads are combinational.
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    input  logic [WIDTH-1:0]  alt_out,
    input  logic [WIDTH-1:0]  alt_oe,
    output logic [WIDTH-1:0]  pin_sync
);
    logic [WIDTH-1:0] dir_q, lat_q, alt_q;
    logic             we_dir, we_lat, we_alt;

    // Decode the write address into per-register strobes.
    always_comb begin
        we_dir = wr_en && (wr_addr == REG_DIR);
        we_lat = wr_en && (wr_addr == REG_LAT);
        we_alt = wr_en && (wr_addr == REG_ALT);
    end

    gpio_maskreg #(.WIDTH(WIDTH)) u_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(we_dir),
        .wr_data(wr_data), .wr_mask(wr_mask), .q(dir_q)
    );
    gpio_maskreg #(.WIDTH(WIDTH)) u_lat (
        .clk(clk), .rst_n(rst_n), .wr_en(we_lat),
        .wr_data(wr_data), .wr_mask(wr_mask), .q(lat_q)
    );
    gpio_maskreg #(.WIDTH(WIDTH)) u_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(we_alt),
        .wr_data(wr_data), .wr_mask(wr_mask), .q(alt_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    gpio_padmux #(.WIDTH(WIDTH)) u_mux (
        .dir_q(dir_q), .lat_q(lat_q), .alt_q(alt_q),
        .alt_out(alt_out), .alt_oe(alt_oe),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Read mux; the pin view blends latch and synchronized input by direction.
    always_comb begin
        case (rd_addr)
            REG_DIR: rd_data = dir_q;
            REG_LAT: rd_data = lat_q;
            REG_ALT: rd_data = alt_q;
            default: rd_data = (dir_q & lat_q) | (~dir_q & pin_sync);
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
// Assertion checker for gpio_port, attached by bind. Observes ports and the
// register outputs; drives nothing.
module gpio_port_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [WIDTH-1:0] wr_data,
    input logic [WIDTH-1:0] wr_mask,
    input logic [WIDTH-1:0] dir_q,
    input logic [WIDTH-1:0] lat_q,
    input logic [WIDTH-1:0] alt_q,
    input logic [WIDTH-1:0] alt_out,
    input logic [WIDTH-1:0] alt_oe,
    input logic [WIDTH-1:0] pad_out,
    input logic [WIDTH-1:0] pad_oe
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dir_q == '0 && lat_q == '0 && alt_q == '0 && pad_oe == '0));

    // R2
    dir_masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=>
            dir_q == (($past(dir_q) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

    // R2
    lat_masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1) |=>
            lat_q == (($past(lat_q) & ~$past(wr_mask)) | ($past(wr_data) & $past(wr_mask))));

    // R3
    input_pin_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~alt_q & ~dir_q) == '0);

    // R4
    alt_pin_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_out ^ alt_out) & alt_q) == '0 && ((pad_oe ^ alt_oe) & alt_q) == '0);

    // R8
    pin_addr_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> ($stable(dir_q) && $stable(lat_q) && $stable(alt_q)));

    // R9
    zero_mask_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_mask == '0) |=> ($stable(dir_q) && $stable(lat_q) && $stable(alt_q)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_mask(wr_mask), .dir_q(dir_q), .lat_q(lat_q),
    .alt_q(alt_q), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/gpio_port_tb_top.sv
// Self-checking bench for gpio_port: seeded random traffic plus directed cases.
module gpio_port_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0, wr_mask = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pad_in = '0, pad_out, pad_oe;
    logic [W-1:0] alt_out = '0, alt_oe = '0, pin_sync;

    int checks = 0;
    int errors = 0;

    // Bench model state.
    logic [W-1:0] m_dir = '0, m_lat = '0, m_alt = '0, m_s1 = '0, m_s2 = '0;

    always #4 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(rd_addr),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .pin_sync(pin_sync)
    );

    function automatic logic [W-1:0] mask_upd(logic [W-1:0] q, logic [W-1:0] d, logic [W-1:0] m);
        return (q & ~m) | (d & m);
    endfunction

    function automatic logic [W-1:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return m_dir;
            2'd1:    return m_lat;
            2'd2:    return m_alt;
            default: return (m_dir & m_lat) | (~m_dir & m_s2);
        endcase
    endfunction

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check every output against the model; inputs are settled.
    task automatic check_all();
        #1;
        chk("R3/R4 pad_out", pad_out, (m_alt & alt_out) | (~m_alt & m_lat));
        chk("R3/R4 pad_oe", pad_oe, (m_alt & alt_oe) | (~m_alt & m_dir));
        chk("R5 pin_sync", pin_sync, m_s2);
        chk(rd_addr == 2'd3 ? "R6 pin read" : "R7 reg read", rd_data, exp_read(rd_addr));
    endtask

    // Advance one clock and update the model with the inputs held across it.
    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            m_dir = '0; m_lat = '0; m_alt = '0; m_s1 = '0; m_s2 = '0;
        end else begin
            if (wr_en && wr_addr == 2'd0) m_dir = mask_upd(m_dir, wr_data, wr_mask);
            if (wr_en && wr_addr == 2'd1) m_lat = mask_upd(m_lat, wr_data, wr_mask);
            if (wr_en && wr_addr == 2'd2) m_alt = mask_upd(m_alt, wr_data, wr_mask);
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [W-1:0] d, logic [W-1:0] m);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_mask = m;
        step();
        wr_en = 1'b0;
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        pad_in = 16'hBEEF;
        step(); step();
        rst_n = 1'b1;
        // R1: reset state through the read port and pads.
        for (int a = 0; a < 3; a++) begin
            rd_addr = 2'(a); #1;
            chk("R1 reg clear", rd_data, '0);
        end
        chk("R1 pad_oe clear", pad_oe, '0);
        chk("R5 sync clear", pin_sync, '0);

        // R2: single-bit writes leave neighbours alone.
        wr(2'd1, 16'hFFFF, 16'h00F0);
        rd_addr = 2'd1; check_all();
        chk("R2 latch bits", rd_data, 16'h00F0);
        wr(2'd0, 16'h0000, 16'hFFFF);
        wr(2'd0, 16'hFFFF, 16'h0010);
        rd_addr = 2'd0; check_all();
        chk("R2 dir single bit", rd_data, 16'h0010);

        // R9: all-zero mask.
        wr(2'd1, 16'h1234, 16'h0000);
        rd_addr = 2'd1; check_all();
        chk("R9 zero mask", rd_data, 16'h00F0);

        // R8: write to pin address changes nothing.
        wr(2'd3, 16'hFFFF, 16'hFFFF);
        for (int a = 0; a < 3; a++) begin
            rd_addr = 2'(a); check_all();
        end
        chk("R8 pad_oe unchanged", pad_oe, 16'h0010);

        // R4: alternate select overrides a latch/direction that disagree.
        alt_out = 16'h0000; alt_oe = 16'h0000;
        wr(2'd2, 16'h0010, 16'h0010);
        check_all();
        chk("R4 override out", pad_out & 16'h0010, 16'h0000);
        chk("R4 override oe", pad_oe & 16'h0010, 16'h0000);

        // R5: latency of two edges.
        pad_in = 16'hA5A5;
        step(); check_all();
        step(); check_all();
        chk("R5 two edges", pin_sync, 16'hA5A5);

        // Random traffic.
        for (int n = 0; n < 600; n++) begin
            wr_en   = 1'($urandom);
            wr_addr = 2'($urandom);
            wr_data = 16'($urandom);
            wr_mask = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
            rd_addr = 2'($urandom);
            pad_in  = 16'($urandom);
            alt_out = 16'($urandom);
            alt_oe  = 16'($urandom);
            check_all();
            step();
        end
        wr_en = 1'b0;
        check_all();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule